// File: doc/BRIEF.md
# Key-Sequenced 64-bit Watchdog Timer

This block is a memory-mapped 64-bit timer that software can turn into a watchdog. Software uses a simple 32-bit register bus. It loads a 64-bit period as two 32-bit halves. It releases both timer halves from reset, selects the watchdog mode and starts the counter in one-shot or periodic mode.

Arming takes two writes to the watchdog control word, in a fixed order. The first carries the arming key and the enable bit, and the second carries the activation key and the enable bit. From the first accepted key onward the timer configuration is locked. Only the key field of the control word stays live, together with the write-one-to-clear timeout flag. Software keeps the system alive by writing the same two keys again, which restarts the count from zero. If the armed counter reaches the period, the flag is set and a reset output pulses for one clock.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, offset 0x00 reads the ID_VALUE parameter, and the control word at 0x28 reads zero. The counter (0x10 low, 0x14 high) and the period (0x18 low, 0x1C high) read zero, and wdReset is low.
- R2: While unlocked, the period halves and counter halves read back what was written. Offset 0x20 keeps only bits 7:6 (run mode) and 0x24 keeps only bits 3:0 (bit 0 and bit 1 release the two halves, bits 3:2 equal to 2 select watchdog mode). Offset 0x00 ignores writes, and unmapped offsets read zero.
- R3: The counter advances by one per clock when bits 1:0 of 0x24 are both 1 and the run mode is 1 or 2. With run mode 0 it holds its value.
- R4: In run mode 2 the counter returns to zero on the clock after it equals the period. In run mode 1 it stops at the period. A write to a counter half takes priority over counting.
- R5: Writing 0x28 with bits 31:16 = 0xA5C6 and bit 14 = 1 from idle, then bits 31:16 = 0xDA7E with bit 14 = 1, arms the watchdog. Bit 14 of 0x28 reads 1 from the first accepted write onward.
- R6: A write whose key is not the next expected one leaves the state unchanged. This covers 0xDA7E from idle, 0xA5C6 without bit 14 from idle, 0xDA7E in the armed active state, and any other key value in the service state.
- R7: From the first accepted key onward, writes to 0x10, 0x14, 0x18, 0x1C, 0x20 and 0x24 are ignored.
- R8: When armed, 0xA5C6 followed later by 0xDA7E clears the whole counter to zero on the clock that accepts 0xDA7E.
- R9: When armed with watchdog mode selected, the counter equalling the period in a counting cycle sets bit 15 of 0x28. It also drives wdReset high for exactly the next clock.
- R10: Writing 0x28 with bit 15 = 1 clears the timeout flag at any time, without changing the state. A timeout in the same clock wins.
- R11: Once armed, only the reset input returns the state to idle, clears bit 14 and unlocks the configuration.
- R12: Offset 0x04 is a plain 32-bit read/write register in every state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous system reset |
| busWe | input | 1 | Write strobe for the addressed register |
| busAddr | input | ADDR_W | Byte offset of the register |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data for busAddr, combinational |
| wdReset | output | 1 | One-clock reset request on timeout |

## Verification
The assertions assume bus addresses are aligned word offsets and that rstN is held low for at least one clock before the first bus cycle. They also assume no write reaches the period registers after locking by any path other than the bus. The stimulus changes inputs only on the falling edge, so each write lands on exactly one rising edge. The period stays small or far away relative to the test windows, so every timeout the checks expect falls at a known clock count after a service.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_PREACT  = 2'd1,
    ST_ACTIVE  = 2'd2,
    ST_SERVICE = 2'd3
  } wdState_e;

  typedef struct packed {
    logic ldCntLo;
    logic ldCntHi;
    logic ldPrdLo;
    logic ldPrdHi;
    logic ldTmrCtl;
    logic ldGlbCtl;
    logic clrCnt;
  } dpStrobe_t;

  localparam int OFS_ID    = 'h00;
  localparam int OFS_EMU   = 'h04;
  localparam int OFS_CNTLO = 'h10;
  localparam int OFS_CNTHI = 'h14;
  localparam int OFS_PRDLO = 'h18;
  localparam int OFS_PRDHI = 'h1C;
  localparam int OFS_TCTL  = 'h20;
  localparam int OFS_GCTL  = 'h24;
  localparam int OFS_WCTL  = 'h28;

  localparam int KEY_W = 16;
  localparam logic [KEY_W-1:0] KEY_SVC = 16'hA5C6;
  localparam logic [KEY_W-1:0] KEY_ACT = 16'hDA7E;

  localparam int EN_BIT   = 14;
  localparam int FLAG_BIT = 15;
  localparam int MODE_LSB = 6;

  localparam logic [1:0] RUN_ONESHOT  = 2'd1;
  localparam logic [1:0] RUN_PERIODIC = 2'd2;
  localparam logic [1:0] GMODE_WDOG   = 2'd2;

endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWe,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [KEY_W-1:0]    keyIn,
  input  logic                enIn,
  input  logic                flagClrIn,
  input  logic                hit,
  input  logic                wdMode,
  output dpStrobe_t           strobe,
  output wdState_e            wdState,
  output logic                flag,
  output logic                wdReset
);

  logic     locked;
  logic     wcSel;
  logic     armed;
  logic     tmo;
  wdState_e nxtState;

  assign locked = (wdState != ST_IDLE);
  assign wcSel  = busWe && (busAddr == ADDR_W'(OFS_WCTL));
  assign armed  = (wdState == ST_ACTIVE) || (wdState == ST_SERVICE);
  assign tmo    = hit && armed && wdMode;

  always_comb begin
    strobe          = '0;
    strobe.ldCntLo  = busWe && !locked && (busAddr == ADDR_W'(OFS_CNTLO));
    strobe.ldCntHi  = busWe && !locked && (busAddr == ADDR_W'(OFS_CNTHI));
    strobe.ldPrdLo  = busWe && !locked && (busAddr == ADDR_W'(OFS_PRDLO));
    strobe.ldPrdHi  = busWe && !locked && (busAddr == ADDR_W'(OFS_PRDHI));
    strobe.ldTmrCtl = busWe && !locked && (busAddr == ADDR_W'(OFS_TCTL));
    strobe.ldGlbCtl = busWe && !locked && (busAddr == ADDR_W'(OFS_GCTL));
    strobe.clrCnt   = wcSel && (wdState == ST_SERVICE) && (keyIn == KEY_ACT);
  end

  always_comb begin
    nxtState = wdState;
    if (wcSel) begin
      unique case (wdState)
        ST_IDLE:    if (keyIn == KEY_SVC && enIn) nxtState = ST_PREACT;
        ST_PREACT:  if (keyIn == KEY_ACT && enIn) nxtState = ST_ACTIVE;
        ST_ACTIVE:  if (keyIn == KEY_SVC)         nxtState = ST_SERVICE;
        ST_SERVICE: if (keyIn == KEY_ACT)         nxtState = ST_ACTIVE;
        default:                                  nxtState = wdState;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wdState <= ST_IDLE;
      flag    <= 1'b0;
      wdReset <= 1'b0;
    end else begin
      wdState <= nxtState;
      wdReset <= tmo;
      if (tmo)
        flag <= 1'b1;
      else if (wcSel && flagClrIn)
        flag <= 1'b0;
    end
  end

endmodule

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  cntVal,
  output logic [CNT_W-1:0]  prdVal,
  output logic [1:0]        tmrMode,
  output logic [3:0]        glbCtl,
  output logic              hit,
  output logic              wdMode
);

  logic [DATA_W-1:0] prdHalf [2];
  logic [1:0]        ldPrd;
  logic              osDone;
  logic              tmrRun;

  assign ldPrd = {strobe.ldPrdHi, strobe.ldPrdLo};

  for (genvar h = 0; h < 2; h++) begin : gPrd
    always_ff @(posedge clk) begin
      if (!rstN)
        prdHalf[h] <= '0;
      else if (ldPrd[h])
        prdHalf[h] <= wdata;
    end
  end

  assign prdVal = {prdHalf[1], prdHalf[0]};

  assign tmrRun = (glbCtl[1:0] == 2'b11) &&
                  ((tmrMode == RUN_PERIODIC) || (tmrMode == RUN_ONESHOT && !osDone));
  assign hit    = tmrRun && (cntVal == prdVal);
  assign wdMode = (glbCtl[3:2] == GMODE_WDOG);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmrMode <= '0;
      glbCtl  <= '0;
    end else begin
      if (strobe.ldTmrCtl) tmrMode <= wdata[MODE_LSB +: 2];
      if (strobe.ldGlbCtl) glbCtl  <= wdata[3:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntVal <= '0;
      osDone <= 1'b0;
    end else if (strobe.clrCnt) begin
      cntVal <= '0;
      osDone <= 1'b0;
    end else if (strobe.ldCntLo || strobe.ldCntHi) begin
      if (strobe.ldCntLo) cntVal[DATA_W-1:0]     <= wdata;
      if (strobe.ldCntHi) cntVal[CNT_W-1:DATA_W] <= wdata;
      osDone <= 1'b0;
    end else if (tmrRun) begin
      if (cntVal == prdVal) begin
        if (tmrMode == RUN_PERIODIC) cntVal <= '0;
        else                         osDone <= 1'b1;
      end else begin
        cntVal <= cntVal + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import wdog_pkg::*;
#(
  parameter int          ADDR_W   = 6,
  parameter int          DATA_W   = 32,
  parameter logic [31:0] ID_VALUE = 32'h5744_0001,
  localparam int         CNT_W    = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              wdReset
);

  dpStrobe_t         strobe;
  wdState_e          wdState;
  logic              flag;
  logic              hit;
  logic              wdMode;
  logic [CNT_W-1:0]  cntVal;
  logic [CNT_W-1:0]  prdVal;
  logic [1:0]        tmrMode;
  logic [3:0]        glbCtl;
  logic [DATA_W-1:0] emuReg;

  wdog_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .busWe     (busWe),
    .busAddr   (busAddr),
    .keyIn     (busWdata[DATA_W-1 -: KEY_W]),
    .enIn      (busWdata[EN_BIT]),
    .flagClrIn (busWdata[FLAG_BIT]),
    .hit       (hit),
    .wdMode    (wdMode),
    .strobe    (strobe),
    .wdState   (wdState),
    .flag      (flag),
    .wdReset   (wdReset)
  );

  wdog_dp #(.DATA_W(DATA_W)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wdata   (busWdata),
    .cntVal  (cntVal),
    .prdVal  (prdVal),
    .tmrMode (tmrMode),
    .glbCtl  (glbCtl),
    .hit     (hit),
    .wdMode  (wdMode)
  );

  always_ff @(posedge clk) begin
    if (!rstN)
      emuReg <= '0;
    else if (busWe && busAddr == ADDR_W'(OFS_EMU))
      emuReg <= busWdata;
  end

  always_comb begin
    busRdata = '0;
    unique case (busAddr)
      ADDR_W'(OFS_ID):    busRdata = DATA_W'(ID_VALUE);
      ADDR_W'(OFS_EMU):   busRdata = emuReg;
      ADDR_W'(OFS_CNTLO): busRdata = cntVal[DATA_W-1:0];
      ADDR_W'(OFS_CNTHI): busRdata = cntVal[CNT_W-1:DATA_W];
      ADDR_W'(OFS_PRDLO): busRdata = prdVal[DATA_W-1:0];
      ADDR_W'(OFS_PRDHI): busRdata = prdVal[CNT_W-1:DATA_W];
      ADDR_W'(OFS_TCTL):  busRdata[MODE_LSB +: 2] = tmrMode;
      ADDR_W'(OFS_GCTL):  busRdata[3:0] = glbCtl;
      ADDR_W'(OFS_WCTL): begin
        busRdata[FLAG_BIT] = flag;
        busRdata[EN_BIT]   = (wdState != ST_IDLE);
      end
      default:            busRdata = '0;
    endcase
  end

endmodule

// File: rtl/wdog_checker.sv
module wdog_checker
  import wdog_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rstN,
  input logic             wdReset,
  input wdState_e         wdState,
  input logic [CNT_W-1:0] cntVal,
  input logic [CNT_W-1:0] prdVal
);

  AST_ARM_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (wdState == ST_ACTIVE) |-> ($past(wdState) != ST_IDLE)); // R5

  AST_PERIOD_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    ($past(wdState) != ST_IDLE) |-> $stable(prdVal)); // R7

  AST_SERVICE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    ((wdState == ST_ACTIVE) && ($past(wdState) == ST_SERVICE)) |-> (cntVal == '0)); // R8

  AST_TMO_AT_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    wdReset |-> $past(cntVal == prdVal)); // R9

  AST_TMO_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rstN)
    wdReset |-> ($past(wdState) == ST_ACTIVE || $past(wdState) == ST_SERVICE)); // R9

  AST_ENABLE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ($past(wdState) != ST_IDLE) |-> (wdState != ST_IDLE)); // R11

endmodule

bind keyed_wdog wdog_checker #(.CNT_W(CNT_W)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .wdReset (wdReset),
  .wdState (wdState),
  .cntVal  (cntVal),
  .prdVal  (prdVal)
);

// File: tb/keyed_wdog_test.sv
module keyed_wdog_test;

  localparam logic [31:0] ID = 32'h5744_0001;
  localparam logic [31:0] K1 = 32'hA5C6_4000;
  localparam logic [31:0] K2 = 32'hDA7E_4000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        wdReset;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  keyed_wdog #(.ID_VALUE(ID)) uut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .wdReset(wdReset)
  );

  always #4 clk = ~clk;

  typedef struct packed {
    logic [5:0]  addr;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic [7:0]  tag;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{6'h18, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 8'd2},
    '{6'h1C, 32'h0000_0042, 32'h0000_0042, 8'd2},
    '{6'h20, 32'hFFFF_FFFF, 32'h0000_00C0, 8'd2},
    '{6'h20, 32'h0000_0000, 32'h0000_0000, 8'd2},
    '{6'h24, 32'hFFFF_FFF0, 32'h0000_0000, 8'd2},
    '{6'h24, 32'h0000_000B, 32'h0000_000B, 8'd2},
    '{6'h14, 32'h0000_0007, 32'h0000_0007, 8'd2},
    '{6'h10, 32'h0000_0055, 32'h0000_0055, 8'd2},
    '{6'h00, 32'hFFFF_FFFF, ID,            8'd2},
    '{6'h04, 32'hCAFE_0001, 32'hCAFE_0001, 8'd12},
    '{6'h30, 32'h0000_0001, 32'h0000_0000, 8'd2}
  };

  task automatic check(input int tag, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, c0, c1;
    int firstHi, nHi;
    doReset();

    // R1 reset state
    rd(6'h00, v); check(1, v, ID, "id after reset");
    rd(6'h28, v); check(1, v, 32'h0, "control word after reset");
    rd(6'h10, v); check(1, v, 32'h0, "counter low after reset");
    rd(6'h1C, v); check(1, v, 32'h0, "period high after reset");
    check(1, {31'h0, wdReset}, 32'h0, "wdReset after reset");

    // R2 / R12 table of write-then-read vectors
    for (int i = 0; i < NV; i++) begin
      wr(VECS[i].addr, VECS[i].wdata);
      rd(VECS[i].addr, v);
      check(int'(VECS[i].tag), v, VECS[i].exp, "table readback");
    end

    // R6 wrong keys from idle leave state idle and config unlocked
    wr(6'h28, K2);
    rd(6'h28, v); check(6, v, 32'h0, "second key from idle");
    wr(6'h28, 32'hA5C6_0000);
    rd(6'h28, v); check(6, v, 32'h0, "first key without enable");
    wr(6'h18, 32'h0000_0005); wr(6'h1C, 32'h0);
    rd(6'h18, v); check(6, v, 32'h5, "period still writable");

    // R3 hold in mode 0, count in mode 2
    wr(6'h24, 32'h3); wr(6'h14, 32'h0); wr(6'h18, 32'd1000);
    rd(6'h10, c0); repeat (7) @(negedge clk); rd(6'h10, c1);
    check(3, c1 - c0, 32'd0, "counter held with run mode 0");
    wr(6'h20, 32'h80); wr(6'h10, 32'h0);
    rd(6'h10, c0); repeat (9) @(negedge clk); rd(6'h10, c1);
    check(3, c1 - c0, 32'd9, "counter advance per clock");

    // R4 periodic wrap with period 5
    wr(6'h18, 32'd5); wr(6'h10, 32'h0);
    rd(6'h10, v); check(4, v, 32'd0, "counter write wins over counting");
    nHi = 0;
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      if (wdReset) nHi++;
    end
    rd(6'h10, v); check(4, v, 32'd1, "periodic wrap after period");
    check(9, nHi, 0, "no reset pulse while unarmed");

    // R4 one-shot stops at period
    wr(6'h20, 32'h40); wr(6'h10, 32'h0);
    repeat (12) @(negedge clk);
    rd(6'h10, v); check(4, v, 32'd5, "one-shot stops at period");

    // Session B: watchdog arm and service
    doReset();
    wr(6'h18, 32'd1000); wr(6'h24, 32'hB); wr(6'h20, 32'h80);
    wr(6'h28, K1);
    rd(6'h28, v); check(5, v, 32'h0000_4000, "enable after first key");
    wr(6'h28, K2);
    rd(6'h28, v); check(5, v, 32'h0000_4000, "enable after second key");

    // R7 lock
    wr(6'h18, 32'd7);  rd(6'h18, v); check(7, v, 32'd1000, "period low locked");
    wr(6'h1C, 32'd5);  rd(6'h1C, v); check(7, v, 32'd0, "period high locked");
    wr(6'h24, 32'h0);  rd(6'h24, v); check(7, v, 32'hB, "global control locked");
    wr(6'h20, 32'h0);  rd(6'h20, v); check(7, v, 32'h80, "run mode locked");
    wr(6'h10, 32'h0);  rd(6'h10, v); check(7, {31'h0, v != 0}, 32'h1, "counter write ignored");

    // R6 second key alone in active does not service
    rd(6'h10, c0); wr(6'h28, K2); rd(6'h10, c1);
    check(6, {31'h0, c1 > c0}, 32'h1, "lone second key no clear");

    // R6 / R8 bad key in service keeps service, then second key clears
    wr(6'h28, K1); wr(6'h28, 32'h1234_4000); wr(6'h28, K2);
    rd(6'h10, v); check(8, v, 32'd0, "service clears counter");
    rd(6'h14, v); check(8, v, 32'd0, "service clears counter high");

    // R9 timeout at period, one clock pulse
    firstHi = -1; nHi = 0;
    for (int k = 1; k <= 1100; k++) begin
      @(negedge clk);
      if (wdReset) begin
        nHi++;
        if (firstHi < 0) firstHi = k;
      end
    end
    check(9, firstHi, 1001, "reset pulse cycle after service");
    check(9, nHi, 1, "reset pulse width");
    rd(6'h28, v); check(9, v, 32'h0000_C000, "flag set after timeout");

    // R10 / R11 flag clear keeps state armed
    wr(6'h28, 32'h0000_8000);
    rd(6'h28, v); check(10, v, 32'h0000_4000, "flag cleared state kept");
    check(11, v, 32'h0000_4000, "enable survives non-key writes");

    // R12 emulation register writable while locked
    wr(6'h04, 32'h0BAD_F00D);
    rd(6'h04, v); check(12, v, 32'h0BAD_F00D, "emulation reg while locked");

    // R11 only reset returns to idle
    doReset();
    rd(6'h28, v); check(11, v, 32'h0, "reset clears enable");
    wr(6'h18, 32'd33);
    rd(6'h18, v); check(11, v, 32'd33, "reset unlocks period");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule